// File: doc/BRIEF.md
# Programming Address Counter with Split Wrap

This block holds the word address used while a small flash microcontroller is being programmed over its serial port. The address space is 14 bits wide. The lower half, 0x0000 to 0x1FFF, is user program memory. The upper half, 0x2000 to 0x3FFF, is configuration memory. The command decoder pulses one strobe to step the address and another to jump to the start of configuration space. A synchronous clear returns the pointer to the first user word.

Each half wraps on its own. The counter steps only the lower 13 bits, so the top bit never changes through stepping. Once the pointer is in configuration space, it stays there until it is cleared.

The block also drives a combinational flag that marks the current address as reserved. Only four identification words (offsets 0 to 3) and one configuration word (offset 7) are usable in configuration space. Every other configuration address is flagged as reserved.

Top module: `prog_addr_ctr`

## Requirements
- R1: While rst_ni is low, addr_o is 0x0000. A cycle with clr_i high sets addr_o to 0x0000 on the next clock edge.
- R2: A cycle with inc_i high, and clr_i and ld_cfg_i low, makes addr_o one greater on the next edge, unless this is a wrap case (R3, R5).
- R3: Stepping from 0x1FFF gives 0x0000.
- R4: A cycle with ld_cfg_i high and clr_i low sets addr_o to 0x2000 on the next edge, from any address.
- R5: Stepping from 0x3FFF gives 0x2000.
- R6: While addr_o bit 13 is 1, it stays 1 on every edge without clr_i. Stepping and loading never return the pointer to user space.
- R7: When ld_cfg_i and inc_i are both high, the load wins and addr_o becomes 0x2000.
- R8: rsvd_o is 1 exactly when addr_o is at or above 0x2000 and is not one of 0x2000, 0x2001, 0x2002, 0x2003 or 0x2007. For every user address rsvd_o is 0.
- R9: A cycle with clr_i, inc_i and ld_cfg_i all low leaves addr_o unchanged.
- R10: clr_i wins over ld_cfg_i and inc_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear to address 0x0000 |
| inc_i | input | 1 | Step the address by one |
| ld_cfg_i | input | 1 | Jump to address 0x2000 |
| addr_o | output | 14 | Current address |
| rsvd_o | output | 1 | Current address is reserved |

## Verification
The assertions check on every cycle:
- the command priorities and the hold, clear and load results;
- the rule that the top bit never falls without a clear;
- rsvd_o being low in user space and on the configuration word.

Only the bench scenarios show the two wrap points, because reaching them takes thousands of steps in one half. The bench scenarios also cover two more points. One is the exact set of reserved offsets, swept across the start of configuration space. The other is that a clear is the only way back to user space.

// File: rtl/prog_addr_pkg.sv
package prog_addr_pkg;
  localparam int ADDR_W       = 14;
  localparam int ID_WORDS     = 4;
  localparam int CFG_WORD_OFS = 7;
endpackage

// File: rtl/prog_addr_next.sv
module prog_addr_next #(
  parameter int AW = 14
) (
  input  logic [AW-1:0] addr_i,
  input  logic          clr_i,
  input  logic          ld_i,
  input  logic          inc_i,
  output logic [AW-1:0] nxt_o
);
  localparam int OW = AW - 1;

  logic [OW-1:0] ofs_inc;

  // step only the offset, so each half wraps on itself
  assign ofs_inc = addr_i[OW-1:0] + OW'(1);

  always_comb begin
    if (clr_i)      nxt_o = '0;
    else if (ld_i)  nxt_o = {1'b1, {OW{1'b0}}};
    else if (inc_i) nxt_o = {addr_i[AW-1], ofs_inc};
    else            nxt_o = addr_i;
  end
endmodule

// File: rtl/prog_addr_class.sv
module prog_addr_class #(
  parameter int AW      = 14,
  parameter int ID_N    = 4,
  parameter int CFG_OFS = 7
) (
  input  logic [AW-1:0] addr_i,
  output logic          rsvd_o
);
  localparam int OW = AW - 1;

  logic [ID_N:0] hit;

  for (genvar i = 0; i < ID_N; i++) begin : g_id
    assign hit[i] = (addr_i[OW-1:0] == OW'(i));
  end
  assign hit[ID_N] = (addr_i[OW-1:0] == OW'(CFG_OFS));

  assign rsvd_o = addr_i[AW-1] & ~(|hit);
endmodule

// File: rtl/prog_addr_ctr.sv
module prog_addr_ctr
  import prog_addr_pkg::*;
#(
  parameter int AW      = ADDR_W,
  parameter int ID_N    = ID_WORDS,
  parameter int CFG_OFS = CFG_WORD_OFS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic          ld_cfg_i,
  output logic [AW-1:0] addr_o,
  output logic          rsvd_o
);
  logic [AW-1:0] addr_q, addr_d;

  prog_addr_next #(.AW(AW)) u_next (
    .addr_i (addr_q),
    .clr_i  (clr_i),
    .ld_i   (ld_cfg_i),
    .inc_i  (inc_i),
    .nxt_o  (addr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= addr_d;
  end

  prog_addr_class #(.AW(AW), .ID_N(ID_N), .CFG_OFS(CFG_OFS)) u_class (
    .addr_i (addr_q),
    .rsvd_o (rsvd_o)
  );

  assign addr_o = addr_q;
endmodule

// File: rtl/prog_addr_ctr_chk.sv
module prog_addr_ctr_chk #(
  parameter int AW      = 14,
  parameter int CFG_OFS = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clr_i,
  input logic          inc_i,
  input logic          ld_cfg_i,
  input logic [AW-1:0] addr_o,
  input logic          rsvd_o
);
  localparam logic [AW-1:0] CFG_BASE = {1'b1, {(AW-1){1'b0}}};

  // R1 and R10: clear wins over every other command
  p_clr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> addr_o == '0);

  p_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && ld_cfg_i) |=> addr_o == CFG_BASE);

  p_load_prio_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && ld_cfg_i && inc_i) |=> addr_o == CFG_BASE);

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !ld_cfg_i && inc_i && addr_o[AW-2:0] != '1)
      |=> addr_o == $past(addr_o) + AW'(1));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !ld_cfg_i && !inc_i) |=> $stable(addr_o));

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_o[AW-1] && !clr_i) |=> addr_o[AW-1]);

  p_user_free_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_o[AW-1] |-> !rsvd_o);

  p_cfg_word_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_o == (CFG_BASE | AW'(CFG_OFS))) |-> !rsvd_o);
endmodule

bind prog_addr_ctr prog_addr_ctr_chk #(.AW(AW), .CFG_OFS(CFG_OFS)) u_chk (.*);

// File: tb/prog_addr_ctr_tb_top.sv
`timescale 1ns/1ps
module prog_addr_ctr_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, inc = 1'b0, ld = 1'b0;
  logic [13:0] addr;
  logic rsvd;
  logic [13:0] exp_a = '0;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  prog_addr_ctr dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .inc_i(inc), .ld_cfg_i(ld),
    .addr_o(addr), .rsvd_o(rsvd)
  );

  function automatic logic exp_rsvd(logic [13:0] a);
    return a[13] && !(a <= 14'h2003 || a == 14'h2007);
  endfunction

  task automatic chk(string req);
    total++;
    if (addr !== exp_a) begin
      bad++;
      $display("FAIL %s addr act=%h exp=%h", req, addr, exp_a);
    end
    total++;
    if (rsvd !== exp_rsvd(exp_a)) begin
      bad++;
      $display("FAIL %s rsvd act=%b exp=%b", req, rsvd, exp_rsvd(exp_a));
    end
  endtask

  // one cycle with the given strobes, then check the model
  task automatic step(logic c, logic i, logic l, string req);
    @(negedge clk);
    clr = c; inc = i; ld = l;
    if (c)      exp_a = '0;
    else if (l) exp_a = 14'h2000;
    else if (i) exp_a = {exp_a[13], exp_a[12:0] + 13'd1};
    @(posedge clk); #2;
    clr = 1'b0; inc = 1'b0; ld = 1'b0;
    chk(req);
  endtask

  task automatic t_reset;
    #2 chk("R1");
    @(negedge clk); rst_n = 1'b1;
    #1 chk("R1");
  endtask

  task automatic t_step_hold;
    for (int k = 0; k < 5; k++) step(0, 1, 0, "R2");
    step(0, 0, 0, "R9");
    step(0, 0, 0, "R9");
  endtask

  task automatic t_user_wrap;
    while (exp_a != 14'h1FFF) step(0, 1, 0, "R2");
    step(0, 1, 0, "R3");
    step(0, 1, 0, "R3");
  endtask

  task automatic t_load;
    for (int k = 0; k < 9; k++) step(0, 1, 0, "R2");
    step(0, 0, 1, "R4");
    step(0, 1, 1, "R7");
  endtask

  task automatic t_rsvd_sweep;
    step(0, 0, 1, "R4");
    for (int k = 0; k < 40; k++) step(0, 1, 0, "R8");
  endtask

  task automatic t_cfg_wrap;
    while (exp_a != 14'h3FFF) step(0, 1, 0, "R6");
    step(0, 1, 0, "R5");
    step(0, 1, 0, "R5");
    step(0, 0, 1, "R6");
  endtask

  task automatic t_clear;
    step(0, 1, 0, "R6");
    step(1, 1, 1, "R10");
    step(0, 1, 0, "R1");
    step(1, 0, 0, "R1");
  endtask

  task automatic t_async_reset;
    step(0, 0, 1, "R4");
    @(negedge clk); rst_n = 1'b0; exp_a = '0;
    #1 chk("R1");
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 0, "R1");
  endtask

  initial begin
    t_reset();
    t_step_hold();
    t_user_wrap();
    t_load();
    t_rsvd_sweep();
    t_cfg_wrap();
    t_clear();
    t_async_reset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule